// File: doc/BRIEF.md
# Split-Bank Compute Mode Controller

This block manages one memory bank that is cut into four pseudo-banks by two address boundaries: an upper/lower cut and a left/right cut. Each pseudo-bank is lent either to the in-memory matrix-vector compute path or to ordinary host read/write service. A one-bit mode register picks the policy. In the wide mode a compute job takes all four pseudo-banks at once, and host traffic waits until the job ends. In the split mode a job takes only the two upper pseudo-banks, and the two lower ones keep serving the host in the same cycles.

Each granted pseudo-bank feeds two compute-unit slots. A job ends when every granted pseudo-bank has reported completion. The controller then raises a one-cycle done pulse and releases its grants. A mode change is only queued when it is requested. It takes effect once no job holds the bank and no host read is still in the memory pipeline. The bank array is a fixed-latency storage stub.

Top module: `pbank_mode_ctrl`

## Requirements
- R1: After reset the mode is wide (`cur_mode_split`=0), nothing is pending, all grants, slot enables, `job_done` and `r_valid` are 0, and both `job_ready` and `h_ready` are 1.
- R2: The pseudo-bank index of a host address is {addr[AW-1], addr[AW-2]}: bit AW-1 selects lower (1) or upper (0), bit AW-2 selects right (1) or left (0). This gives TL=0, TR=1, BL=2, BR=3. Every address holds its own data.
- R3: In wide mode an accepted `job_start` sets `pb_grant`=4'b1111 from the next cycle. While any grant is held, `h_ready` is 0 for every address.
- R4: In split mode an accepted `job_start` sets `pb_grant`=4'b0011 (TL, TR). While the job runs, host requests to TL/TR see `h_ready`=0 and requests to BL/BR are accepted and served.
- R5: Compute-unit slots 2i and 2i+1 of `cu_slot_en` are enabled exactly while `pb_grant[i]` is set.
- R6: `job_done` is a one-cycle pulse in the cycle after the cycle in which the last granted pseudo-bank's `cu_done` bit has been seen. `pb_grant` is 0 in that same cycle. `cu_done` bits of pseudo-banks that are not granted have no effect.
- R7: A mode request is held pending while a job runs or a host read is in flight. While it is pending, `h_ready` and `job_ready` are 0. It is applied one cycle after the bank becomes idle.
- R8: A read accepted in cycle c returns `r_valid`=1 with the last written data in cycle c+LAT. Back-to-back reads return in acceptance order.
- R9: A stalled host request is never dropped. It is accepted as soon as its pseudo-bank is released.
- R10: `job_start` while `job_ready` is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_req_valid | input | 1 | Request a mode change |
| mode_req_split | input | 1 | Requested mode: 1 split, 0 wide |
| cur_mode_split | output | 1 | Current mode |
| mode_pending | output | 1 | Mode request waiting for idle |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request accepted this cycle |
| h_write | input | 1 | 1 write, 0 read |
| h_addr | input | AW | Host address |
| h_wdata | input | DW | Host write data |
| r_valid | output | 1 | Read response valid |
| r_data | output | DW | Read response data |
| job_start | input | 1 | Start a compute job |
| job_ready | output | 1 | A job may start |
| cu_done | input | 4 | Per pseudo-bank completion |
| pb_grant | output | 4 | Pseudo-banks granted to compute |
| cu_slot_en | output | 4*CU_PER_PB | Compute-unit slot enables |
| job_done | output | 1 | Job completion pulse |

## Verification
Grants and slot enables appear in the cycle after the `job_start` acceptance cycle. `job_done` and the grant release appear one cycle after the last completion bit. A queued mode takes effect two cycles after a job's last completion, or LAT+2 cycles after a read accepted with the request. Read data arrives exactly LAT cycles after acceptance. The bench drives inputs at the falling edge and reads registered outputs at that same edge. It settles briefly before reading `h_ready`, which depends on the address. It checks each result in the cycle in which it is due, and also checks the cycle before, so early or late responses both fail.

// File: rtl/pbank_pkg.sv
package pbank_pkg;
    localparam int NPB = 4;

    typedef enum logic {
        MODE_WIDE  = 1'b0,
        MODE_SPLIT = 1'b1
    } mode_e;

    localparam logic [NPB-1:0] WIDE_MASK  = 4'b1111;
    localparam logic [NPB-1:0] SPLIT_MASK = 4'b0011;

    typedef struct packed {
        mode_e          mode;
        logic           pend;
        mode_e          pend_mode;
        logic           busy;
        logic [NPB-1:0] grant;
        logic [NPB-1:0] seen;
        logic           done;
    } ctrl_s;
endpackage

// File: rtl/pbank_decode.sv
module pbank_decode
    import pbank_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic [AW-1:0]  addr,
    input  logic [NPB-1:0] grant,
    output logic [1:0]     idx,
    output logic           blocked
);
    always_comb begin
        idx     = {addr[AW-1], addr[AW-2]};
        blocked = grant[idx];
    end
endmodule

// File: rtl/pbank_mem_stub.sv
module pbank_mem_stub #(
    parameter int AW  = 6,
    parameter int DW  = 8,
    parameter int LAT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          rsp_valid,
    output logic [DW-1:0] rsp_data,
    output logic          in_flight
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0]  mem [DEPTH];
    logic [LAT-1:0] vld_d, vld_q;
    logic [DW-1:0]  dat_d [LAT];
    logic [DW-1:0]  dat_q [LAT];

    always_comb begin
        vld_d[0] = acc && !we;
        dat_d[0] = mem[addr];
        for (int i = 1; i < LAT; i++) begin
            vld_d[i] = vld_q[i-1];
            dat_d[i] = dat_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < LAT; i++) dat_q[i] <= '0;
        end else begin
            vld_q <= vld_d;
            for (int i = 0; i < LAT; i++) dat_q[i] <= dat_d[i];
        end
    end

    always_ff @(posedge clk) begin
        if (acc && we) mem[addr] <= wdata;
    end

    assign rsp_valid = vld_q[LAT-1];
    assign rsp_data  = dat_q[LAT-1];
    assign in_flight = |vld_q;
endmodule

// File: rtl/pbank_mode_ctrl.sv
module pbank_mode_ctrl
    import pbank_pkg::*;
#(
    parameter int AW        = 6,
    parameter int DW        = 8,
    parameter int LAT       = 3,
    parameter int CU_PER_PB = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     mode_req_valid,
    input  logic                     mode_req_split,
    output logic                     cur_mode_split,
    output logic                     mode_pending,
    input  logic                     h_valid,
    output logic                     h_ready,
    input  logic                     h_write,
    input  logic [AW-1:0]            h_addr,
    input  logic [DW-1:0]            h_wdata,
    output logic                     r_valid,
    output logic [DW-1:0]            r_data,
    input  logic                     job_start,
    output logic                     job_ready,
    input  logic [NPB-1:0]           cu_done,
    output logic [NPB-1:0]           pb_grant,
    output logic [NPB*CU_PER_PB-1:0] cu_slot_en,
    output logic                     job_done
);
    ctrl_s     q, d;
    logic [1:0] h_idx;
    logic      h_blocked;
    logic      rd_in_flight;
    logic      h_acc;
    logic [NPB-1:0] seen_n;

    pbank_decode #(.AW(AW)) u_dec (
        .addr    (h_addr),
        .grant   (q.grant),
        .idx     (h_idx),
        .blocked (h_blocked)
    );

    assign h_ready   = !q.pend && !h_blocked;
    assign job_ready = !q.busy && !q.pend;
    assign h_acc     = h_valid && h_ready;

    pbank_mem_stub #(.AW(AW), .DW(DW), .LAT(LAT)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (h_acc),
        .we        (h_write),
        .addr      (h_addr),
        .wdata     (h_wdata),
        .rsp_valid (r_valid),
        .rsp_data  (r_data),
        .in_flight (rd_in_flight)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        seen_n = q.seen | (cu_done & q.grant);

        // queued mode applies only on an idle bank
        if (q.pend && !q.busy && !rd_in_flight) begin
            d.mode = q.pend_mode;
            d.pend = 1'b0;
        end
        if (mode_req_valid) begin
            d.pend      = 1'b1;
            d.pend_mode = mode_e'(mode_req_split);
        end

        if (job_start && job_ready) begin
            d.busy  = 1'b1;
            d.grant = (q.mode == MODE_SPLIT) ? SPLIT_MASK : WIDE_MASK;
            d.seen  = '0;
        end else if (q.busy) begin
            if (seen_n == q.grant) begin
                d.busy  = 1'b0;
                d.grant = '0;
                d.seen  = '0;
                d.done  = 1'b1;
            end else begin
                d.seen = seen_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{mode: MODE_WIDE, pend: 1'b0, pend_mode: MODE_WIDE,
                   busy: 1'b0, grant: '0, seen: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    for (genvar i = 0; i < NPB; i++) begin : g_slot
        assign cu_slot_en[i*CU_PER_PB +: CU_PER_PB] = {CU_PER_PB{q.grant[i]}};
    end

    assign cur_mode_split = (q.mode == MODE_SPLIT);
    assign mode_pending   = q.pend;
    assign pb_grant       = q.grant;
    assign job_done       = q.done;
endmodule

// File: rtl/pbank_mode_ctrl_chk.sv
module pbank_mode_ctrl_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cur_mode_split,
    input logic          mode_pending,
    input logic          h_valid,
    input logic          h_ready,
    input logic [AW-1:0] h_addr,
    input logic          job_start,
    input logic          job_ready,
    input logic [3:0]    pb_grant,
    input logic          job_done
);
    a_r3_wide_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (job_start && job_ready && !cur_mode_split) |=> (pb_grant == 4'b1111));

    a_r3_wide_host_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_mode_split && pb_grant != 4'b0) |-> !h_ready);

    a_r4_split_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (job_start && job_ready && cur_mode_split) |=> (pb_grant == 4'b0011));

    a_r4_split_owner_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (h_valid && pb_grant[{h_addr[AW-1], h_addr[AW-2]}]) |-> !h_ready);

    a_r6_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        job_done |-> (pb_grant == 4'b0));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        job_done |=> !job_done);

    a_r7_switch_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_mode_split != $past(cur_mode_split)) |-> ($past(pb_grant) == 4'b0));

    a_r7_pending_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        mode_pending |-> (!h_ready && !job_ready));
endmodule

bind pbank_mode_ctrl pbank_mode_ctrl_chk #(.AW(AW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cur_mode_split (cur_mode_split),
    .mode_pending   (mode_pending),
    .h_valid        (h_valid),
    .h_ready        (h_ready),
    .h_addr         (h_addr),
    .job_start      (job_start),
    .job_ready      (job_ready),
    .pb_grant       (pb_grant),
    .job_done       (job_done)
);

// File: tb/tb_pbank_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pbank_mode_ctrl;
    localparam int AW = 6, DW = 8, LAT = 3, CPB = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic mode_req_valid = 0, mode_req_split = 0, cur_mode_split, mode_pending;
    logic h_valid = 0, h_ready, h_write = 0;
    logic [AW-1:0] h_addr = '0;
    logic [DW-1:0] h_wdata = '0, r_data;
    logic r_valid, job_start = 0, job_ready, job_done;
    logic [3:0] cu_done = '0, pb_grant;
    logic [4*CPB-1:0] cu_slot_en;

    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    pbank_mode_ctrl #(.AW(AW), .DW(DW), .LAT(LAT), .CU_PER_PB(CPB)) dut (.*);

    function automatic logic [DW-1:0] dat(int a);
        return DW'((a * 37 + 11) & 8'hFF);
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic host_write(int a, logic [DW-1:0] v);
        h_valid = 1; h_write = 1; h_addr = AW'(a); h_wdata = v; #1;
        while (!h_ready) begin @(negedge clk); #1; end
        @(negedge clk); h_valid = 0; h_write = 0;
    endtask

    task automatic host_read(int a, logic [DW-1:0] v, string req);
        h_valid = 1; h_write = 0; h_addr = AW'(a); #1;
        while (!h_ready) begin @(negedge clk); #1; end
        for (int k = 1; k <= LAT; k++) begin
            @(negedge clk);
            if (k == 1) h_valid = 0;
            if (k == LAT - 1) chk(!r_valid, req, "early r_valid", int'(r_valid), 0);
            if (k == LAT) begin
                chk(r_valid, req, "r_valid", int'(r_valid), 1);
                chk(r_data == v, req, "r_data", int'(r_data), int'(v));
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1 reset state
        chk(!cur_mode_split && !mode_pending, "R1", "mode", int'(cur_mode_split), 0);
        chk(pb_grant == 0 && cu_slot_en == 0, "R1", "grant", int'(pb_grant), 0);
        chk(job_ready && h_ready, "R1", "ready", int'({job_ready, h_ready}), 3);
        chk(!r_valid && !job_done, "R1", "pulses", int'({r_valid, job_done}), 0);

        // R2 / R8: every address in every pseudo-bank holds its own data
        for (int a = 0; a < 64; a++) host_write(a, dat(a));
        for (int a = 0; a < 64; a++) host_read(a, dat(a), "R2_R8");

        // R8 back-to-back reads return in order
        for (int i = 0; i < 4 + LAT; i++) begin
            if (i < 4) begin
                h_valid = 1; h_write = 0; h_addr = AW'(i * 17 + 1);
            end else h_valid = 0;
            #1;
            if (i < 4) chk(h_ready, "R8", "burst ready", int'(h_ready), 1);
            if (i >= LAT) begin
                chk(r_valid, "R8", "burst r_valid", int'(r_valid), 1);
                chk(r_data == dat((i - LAT) * 17 + 1), "R8", "burst order",
                    int'(r_data), int'(dat((i - LAT) * 17 + 1)));
            end
            @(negedge clk);
        end

        // R3 wide job
        job_start = 1; #1;
        chk(job_ready, "R3", "job_ready", int'(job_ready), 1);
        @(negedge clk); job_start = 0;
        chk(pb_grant == 4'hF, "R3", "wide grant", int'(pb_grant), 15);
        chk(cu_slot_en == 8'hFF, "R5", "slots wide", int'(cu_slot_en), 255);
        for (int p = 0; p < 4; p++) begin
            h_addr = AW'(p * 16 + 5); #1;
            chk(!h_ready, "R3", "host held", int'(h_ready), 0);
        end
        // R10 start while busy ignored
        job_start = 1; #1;
        chk(!job_ready, "R10", "job_ready busy", int'(job_ready), 0);
        @(negedge clk); job_start = 0;
        chk(pb_grant == 4'hF, "R10", "grant unchanged", int'(pb_grant), 15);
        // R6 completion in pieces
        cu_done = 4'b0001; @(negedge clk);
        cu_done = 4'b0100;
        chk(!job_done && pb_grant == 4'hF, "R6", "partial", int'(job_done), 0);
        @(negedge clk); cu_done = 4'b1010;
        chk(!job_done, "R6", "partial2", int'(job_done), 0);
        @(negedge clk); cu_done = 0;
        chk(job_done, "R6", "done pulse", int'(job_done), 1);
        chk(pb_grant == 0 && cu_slot_en == 0, "R6", "released", int'(pb_grant), 0);
        @(negedge clk);
        chk(!job_done, "R6", "pulse width", int'(job_done), 0);
        chk(pb_grant == 0, "R10", "no ghost job", int'(pb_grant), 0);
        h_addr = 0; #1;
        chk(h_ready && job_ready, "R3", "host free", int'(h_ready), 1);

        // R7 mode change held while busy
        job_start = 1; @(negedge clk); job_start = 0;
        mode_req_valid = 1; mode_req_split = 1;
        @(negedge clk); mode_req_valid = 0; #1;
        chk(mode_pending && !cur_mode_split, "R7", "pending", int'(mode_pending), 1);
        chk(!h_ready && !job_ready, "R7", "pending blocks", int'({h_ready, job_ready}), 0);
        repeat (2) @(negedge clk);
        chk(mode_pending && !cur_mode_split, "R7", "still held", int'(cur_mode_split), 0);
        cu_done = 4'hF; @(negedge clk); cu_done = 0;
        chk(job_done && !cur_mode_split, "R7", "not yet", int'(cur_mode_split), 0);
        @(negedge clk);
        chk(cur_mode_split && !mode_pending, "R7", "applied", int'(cur_mode_split), 1);

        // R4 split job
        job_start = 1; @(negedge clk); job_start = 0;
        chk(pb_grant == 4'b0011, "R4", "split grant", int'(pb_grant), 3);
        chk(cu_slot_en == 8'h0F, "R5", "slots split", int'(cu_slot_en), 15);
        for (int p = 0; p < 4; p++) begin
            h_addr = AW'(p * 16 + 2); #1;
            chk(h_ready == (p >= 2), "R4", "owner ready", int'(h_ready), int'(p >= 2));
        end
        host_write(3 * 16 + 2, 8'h5A);
        host_read(3 * 16 + 2, 8'h5A, "R4");
        host_read(2 * 16 + 9, dat(2 * 16 + 9), "R4");
        // R6 completion from non-granted banks ignored
        cu_done = 4'b1100; @(negedge clk); cu_done = 0;
        chk(!job_done && pb_grant == 4'b0011, "R6", "ignored bits", int'(pb_grant), 3);
        // R9 stalled request survives
        h_valid = 1; h_write = 1; h_addr = AW'(3); h_wdata = 8'hC3; #1;
        chk(!h_ready, "R9", "stalled", int'(h_ready), 0);
        @(negedge clk); #1;
        chk(!h_ready, "R9", "stalled2", int'(h_ready), 0);
        cu_done = 4'b0011; @(negedge clk); cu_done = 0; #1;
        chk(job_done, "R6", "split done", int'(job_done), 1);
        chk(h_ready, "R9", "released", int'(h_ready), 1);
        @(negedge clk); h_valid = 0; h_write = 0;
        host_read(3, 8'hC3, "R9");

        // R7 mode change held while a read is in flight
        h_valid = 1; h_write = 0; h_addr = AW'(10);
        mode_req_valid = 1; mode_req_split = 0; #1;
        chk(h_ready, "R7", "read accepted", int'(h_ready), 1);
        @(negedge clk); h_valid = 0; mode_req_valid = 0;
        chk(mode_pending, "R7", "pend inflight", int'(mode_pending), 1);
        for (int k = 2; k <= LAT + 1; k++) begin
            @(negedge clk);
            if (k == LAT) chk(r_valid && r_data == dat(10), "R8", "inflight data", int'(r_data), int'(dat(10)));
            if (k == LAT + 1) chk(mode_pending && cur_mode_split, "R7", "drain hold", int'(cur_mode_split), 1);
        end
        @(negedge clk);
        chk(!cur_mode_split && !mode_pending, "R7", "back to wide", int'(cur_mode_split), 0);

        summary();
        $finish;
    end
endmodule